// File: doc/BRIEF.md
# I2C Master Interrupt Status Controller

This block collects the event strobes of an I2C master peripheral into a sticky status register. It qualifies them with a per-bit enable register and a single global enable bit, and drives one registered interrupt line. Event pulses arrive from the bus engine and the FIFO logic. A host reads and clears the status through a plain 32-bit register port with address, write strobe, write data and combinational read data.

The same register port holds a keyed soft-reset register. Writing the key value produces a one-cycle reset strobe. That strobe clears the status, enable and global enable registers, and it is also driven out to the neighbouring submodules. Any other value written there does nothing.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: After the reset input is released, every register reads 0, `irq_o` is 0 and `soft_rst_o` is 0.
- R2: A high `evt_i[i]` sets status bit i at the next clock edge, and the bit stays set until it is cleared. The bit map is: 0 arbitration lost, 1 transmit error or transfer done, 2 transmit FIFO empty, 3 receive FIFO at level, 4 bus idle, 5 addressed as target, 6 no longer addressed as target, 7 transmit FIFO half empty.
- R3: A write to the status register at offset 0x20 clears exactly the status bits that are 1 in the write data. All other status bits keep their value.
- R4: If an event and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R5: `irq_o` is a register. One edge after the status settles, it equals the global enable bit ANDed with the OR over all bits of (status AND enable).
- R6: While global enable bit 31 at offset 0x1C is 0, `irq_o` stays 0 whatever is pending.
- R7: The enable register at offset 0x28 reads back the low 8 bits last written, with all upper bits 0. Offset 0x1C reads back bit 31 as last written, with all other bits 0. Status bits 31..8 read as 0.
- R8: Writing exactly 0x0000000A to offset 0x40 raises `soft_rst_o` for one cycle, starting the edge after the write. At the edge that ends the pulse, status, enable and global enable are cleared and `irq_o` goes to 0.
- R9: A write of any other value to offset 0x40 raises no reset pulse and changes no register.
- R10: Writes to addresses other than 0x1C, 0x20, 0x28 and 0x40 change no register, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_i | input | 8 | Event strobes, one per status bit |
| irq_o | output | 1 | Registered interrupt request |
| soft_rst_o | output | 1 | One-cycle soft-reset strobe to the other submodules |

## Verification
The hardest case to reach from the ports is a host clear and an event landing on the same status bit in the same cycle. The bench drives the status write and the event strobe on the same falling edge, so both are sampled at one rising edge. The interrupt equation is swept over all 256 status patterns, each against three enable masks and both global enable values. The key comparison is probed with near-miss values that differ from the key only in low or high bits.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_GIE  = 3'd1,
      SEL_STAT = 3'd2,
      SEL_EN   = 3'd3,
      SEL_RST  = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
   import irqc_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int OFF_GIE  = 'h1C,
   parameter int OFF_STAT = 'h20,
   parameter int OFF_EN   = 'h28,
   parameter int OFF_RST  = 'h40
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   localparam logic [ADDR_W-1:0] A_GIE  = ADDR_W'(OFF_GIE);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);
   localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(OFF_RST);

   always_comb begin
      if (addr == A_GIE)       sel = SEL_GIE;
      else if (addr == A_STAT) sel = SEL_STAT;
      else if (addr == A_EN)   sel = SEL_EN;
      else if (addr == A_RST)  sel = SEL_RST;
      else                     sel = SEL_NONE;
   end
endmodule

// File: rtl/irqc_status_bank.sv
module irqc_status_bank #(
   parameter int NUM_EVT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wipe,
   input  logic [NUM_EVT-1:0] evt,
   input  logic [NUM_EVT-1:0] clr,
   output logic [NUM_EVT-1:0] stat
);
   for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stat[i] <= 1'b0;
         else if (wipe)   stat[i] <= 1'b0;
         else if (evt[i]) stat[i] <= 1'b1;
         else if (clr[i]) stat[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs
   import irqc_pkg::*;
#(
   parameter int          NUM_EVT = 8,
   parameter int          DATA_W  = 32,
   parameter int          GIE_BIT = 31,
   parameter logic [31:0] RST_KEY = 32'hA
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  reg_sel_e           sel,
   input  logic [DATA_W-1:0]  wdata,
   output logic [NUM_EVT-1:0] en_q,
   output logic               gie_q,
   output logic               srst_q
);
   localparam logic [DATA_W-1:0] KEY = DATA_W'(RST_KEY);

   logic key_hit;
   assign key_hit = we && (sel == SEL_RST) && (wdata == KEY) && !srst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         gie_q  <= 1'b0;
         srst_q <= 1'b0;
      end else begin
         srst_q <= key_hit;
         if (srst_q) begin
            en_q  <= '0;
            gie_q <= 1'b0;
         end else if (we) begin
            if (sel == SEL_EN)  en_q  <= wdata[NUM_EVT-1:0];
            if (sel == SEL_GIE) gie_q <= wdata[GIE_BIT];
         end
      end
   end
endmodule

// File: rtl/irqc_irq_out.sv
module irqc_irq_out #(
   parameter int NUM_EVT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wipe,
   input  logic [NUM_EVT-1:0] stat,
   input  logic [NUM_EVT-1:0] en,
   input  logic               gie,
   output logic               irq_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    irq_q <= 1'b0;
      else if (wipe) irq_q <= 1'b0;
      else           irq_q <= gie & (|(stat & en));
   end
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          DATA_W   = 32,
   parameter int          NUM_EVT  = 8,
   parameter int          GIE_BIT  = 31,
   parameter int          OFF_GIE  = 'h1C,
   parameter int          OFF_STAT = 'h20,
   parameter int          OFF_EN   = 'h28,
   parameter int          OFF_RST  = 'h40,
   parameter logic [31:0] RST_KEY  = 32'hA
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_we,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_EVT-1:0] evt_i,
   output logic               irq_o,
   output logic               soft_rst_o
);
   if (NUM_EVT < 1 || NUM_EVT > GIE_BIT) begin : g_bad_evt
      $error("NUM_EVT must be between 1 and GIE_BIT");
   end
   if (GIE_BIT >= DATA_W) begin : g_bad_gie
      $error("GIE_BIT must lie inside DATA_W");
   end
   if ((1 << ADDR_W) <= OFF_RST || (1 << ADDR_W) <= OFF_EN) begin : g_bad_addr
      $error("ADDR_W too narrow for the register offsets");
   end
   if (OFF_GIE == OFF_STAT || OFF_GIE == OFF_EN || OFF_GIE == OFF_RST ||
       OFF_STAT == OFF_EN || OFF_STAT == OFF_RST || OFF_EN == OFF_RST) begin : g_bad_map
      $error("register offsets must be distinct");
   end

   reg_sel_e           sel;
   logic [NUM_EVT-1:0] stat_q;
   logic [NUM_EVT-1:0] en_q;
   logic               gie_q;
   logic               srst_q;
   logic [NUM_EVT-1:0] clr_mask;

   irqc_decode #(
      .ADDR_W(ADDR_W), .OFF_GIE(OFF_GIE), .OFF_STAT(OFF_STAT),
      .OFF_EN(OFF_EN), .OFF_RST(OFF_RST)
   ) u_dec (
      .addr(reg_addr),
      .sel (sel)
   );

   assign clr_mask = (reg_we && sel == SEL_STAT) ? reg_wdata[NUM_EVT-1:0] : '0;

   irqc_status_bank #(.NUM_EVT(NUM_EVT)) u_stat (
      .clk  (clk),
      .rst_n(rst_n),
      .wipe (srst_q),
      .evt  (evt_i),
      .clr  (clr_mask),
      .stat (stat_q)
   );

   irqc_ctrl_regs #(
      .NUM_EVT(NUM_EVT), .DATA_W(DATA_W), .GIE_BIT(GIE_BIT), .RST_KEY(RST_KEY)
   ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we),
      .sel   (sel),
      .wdata (reg_wdata),
      .en_q  (en_q),
      .gie_q (gie_q),
      .srst_q(srst_q)
   );

   irqc_irq_out #(.NUM_EVT(NUM_EVT)) u_irq (
      .clk  (clk),
      .rst_n(rst_n),
      .wipe (srst_q),
      .stat (stat_q),
      .en   (en_q),
      .gie  (gie_q),
      .irq_q(irq_o)
   );

   assign soft_rst_o = srst_q;

   always_comb begin
      reg_rdata = '0;
      case (sel)
         SEL_STAT: reg_rdata = DATA_W'(stat_q);
         SEL_EN:   reg_rdata = DATA_W'(en_q);
         SEL_GIE:  reg_rdata[GIE_BIT] = gie_q;
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/i2c_irq_ctrl_chk.sv
module i2c_irq_ctrl_chk #(
   parameter int          ADDR_W   = 8,
   parameter int          DATA_W   = 32,
   parameter int          NUM_EVT  = 8,
   parameter int          OFF_STAT = 'h20,
   parameter int          OFF_RST  = 'h40,
   parameter logic [31:0] RST_KEY  = 32'hA
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic               reg_we,
   input logic [DATA_W-1:0]  reg_wdata,
   input logic [NUM_EVT-1:0] evt_i,
   input logic               irq_o,
   input logic               soft_rst_o,
   input logic [NUM_EVT-1:0] stat,
   input logic [NUM_EVT-1:0] en,
   input logic               gie
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(OFF_RST);
   localparam logic [DATA_W-1:0] KEY    = DATA_W'(RST_KEY);

   // R2 and R4: an event always lands in its status bit
   p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_i && !soft_rst_o) |=> ((stat & $past(evt_i)) == $past(evt_i)));

   // R3: a clear with no event present removes the masked bits
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_STAT && evt_i == '0) |=>
         ((stat & $past(reg_wdata[NUM_EVT-1:0])) == '0));

   // R5: interrupt follows pending state one edge later
   p_irq_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_rst_o |=> (irq_o == $past(gie && (|(stat & en)))));

   // R6: global enable off keeps the line low
   p_gie_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |=> !irq_o);

   // R8: reset strobe is one cycle and wipes the registers
   p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |=> !soft_rst_o);
   p_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |=> (stat == '0 && en == '0 && !gie && !irq_o));

   // R9: a wrong key raises nothing
   p_bad_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_RST && reg_wdata != KEY) |=> !soft_rst_o);
endmodule

bind i2c_irq_ctrl i2c_irq_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_EVT(NUM_EVT),
   .OFF_STAT(OFF_STAT), .OFF_RST(OFF_RST), .RST_KEY(RST_KEY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .evt_i     (evt_i),
   .irq_o     (irq_o),
   .soft_rst_o(soft_rst_o),
   .stat      (stat_q),
   .en        (en_q),
   .gie       (gie_q)
);

// File: tb/i2c_irq_ctrl_tb.sv
module i2c_irq_ctrl_tb;
   localparam logic [7:0] A_GIE = 8'h1C, A_ST = 8'h20, A_EN = 8'h28, A_RS = 8'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [7:0]  evt = '0;
   logic        irq;
   logic        srst;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   i2c_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we),
      .reg_wdata(wdata), .reg_rdata(rdata), .evt_i(evt),
      .irq_o(irq), .soft_rst_o(srst)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; we = 1'b1; wdata = d;
      @(negedge clk);
      we = 1'b0; wdata = '0; addr = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
      addr = '0;
   endtask

   task automatic pulse(input logic [7:0] e);
      @(negedge clk);
      evt = e;
      @(negedge clk);
      evt = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic [7:0]  en;
      logic        exp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(A_GIE, r); check("R1 gie", r, 0);
      rd(A_ST, r);  check("R1 stat", r, 0);
      rd(A_EN, r);  check("R1 en", r, 0);
      rd(A_RS, r);  check("R1 rst reg", r, 0);
      check("R1 irq", {31'd0, irq}, 0);
      check("R1 srst", {31'd0, srst}, 0);

      // R7 readback
      wr(A_EN, 32'hFFFF_FFFF);  rd(A_EN, r);  check("R7 en readback", r, 32'h0000_00FF);
      wr(A_EN, 32'h1234_5696);  rd(A_EN, r);  check("R7 en readback", r, 32'h0000_0096);
      wr(A_GIE, 32'hFFFF_FFFF); rd(A_GIE, r); check("R7 gie readback", r, 32'h8000_0000);
      wr(A_GIE, 32'h7FFF_FFFF); rd(A_GIE, r); check("R7 gie readback", r, 32'h0000_0000);
      pulse(8'hFF); rd(A_ST, r); check("R7 stat upper zero", r, 32'h0000_00FF);

      // R10 unmapped addresses
      wr(8'h24, 32'hFFFF_FFFF); wr(8'h2C, 32'hFFFF_FFFF); wr(8'h21, 32'hFFFF_FFFF);
      rd(A_ST, r);  check("R10 stat untouched", r, 32'hFF);
      rd(A_EN, r);  check("R10 en untouched", r, 32'h96);
      rd(A_GIE, r); check("R10 gie untouched", r, 0);
      rd(8'h24, r); check("R10 unmapped read", r, 0);

      // R2 bit positions
      for (int i = 0; i < 8; i++) begin
         wr(A_ST, 32'hFF);
         pulse(8'(1 << i));
         rd(A_ST, r);
         check("R2 bit position", r, 32'(1 << i));
      end

      // R5/R6 sweep
      for (int g = 0; g < 2; g++) begin
         wr(A_GIE, 32'(g) << 31);
         for (int s = 0; s < 256; s++) begin
            for (int k = 0; k < 3; k++) begin
               en = (k == 0) ? (8'(s) ^ 8'h5A) : (k == 1) ? ~8'(s) : 8'hFF;
               exp = (g == 1) && ((8'(s) & en) != 8'h00);
               wr(A_ST, 32'hFF);
               wr(A_EN, 32'(en));
               pulse(8'(s));
               check("R5 irq latency", {31'd0, irq}, 0);
               @(negedge clk);
               check(g ? "R5 irq value" : "R6 gie off", {31'd0, irq}, {31'd0, exp});
               rd(A_ST, r);
               check("R2 stat pattern", r, 32'(s));
            end
         end
      end

      // R6 gie drop while pending
      wr(A_EN, 32'h01); wr(A_GIE, 32'h8000_0000); pulse(8'h01); @(negedge clk);
      check("R6 irq before drop", {31'd0, irq}, 1);
      wr(A_GIE, 32'h0); @(negedge clk);
      check("R6 irq after drop", {31'd0, irq}, 0);

      // R3 masked clear
      pulse(8'hFF);
      wr(A_ST, 32'h0F); rd(A_ST, r); check("R3 partial clear", r, 32'hF0);
      wr(A_ST, 32'h00); rd(A_ST, r); check("R3 zero mask", r, 32'hF0);
      wr(A_ST, 32'hFFFF_FF90); rd(A_ST, r); check("R3 upper mask", r, 32'h60);

      // R4 event vs clear in the same cycle
      wr(A_ST, 32'hFF);
      pulse(8'h03);
      @(negedge clk);
      addr = A_ST; we = 1'b1; wdata = 32'h03; evt = 8'h01;
      @(negedge clk);
      we = 1'b0; wdata = '0; addr = '0; evt = '0;
      rd(A_ST, r); check("R4 set wins", r, 32'h01);
      @(negedge clk);
      addr = A_ST; we = 1'b1; wdata = 32'h80; evt = 8'h80;
      @(negedge clk);
      we = 1'b0; wdata = '0; addr = '0; evt = '0;
      rd(A_ST, r); check("R4 set wins new bit", r, 32'h81);

      // R9 wrong keys
      wr(A_ST, 32'hFF); pulse(8'h0C);
      wr(A_EN, 32'h3C); wr(A_GIE, 32'h8000_0000);
      wr(A_RS, 32'h0000_000B); check("R9 no pulse 0B", {31'd0, srst}, 0);
      wr(A_RS, 32'h0000_001A); check("R9 no pulse 1A", {31'd0, srst}, 0);
      wr(A_RS, 32'h8000_000A); check("R9 no pulse hi", {31'd0, srst}, 0);
      wr(8'h41, 32'h0000_000A); check("R9 no pulse addr", {31'd0, srst}, 0);
      rd(A_ST, r);  check("R9 stat kept", r, 32'h0C);
      rd(A_EN, r);  check("R9 en kept", r, 32'h3C);
      rd(A_GIE, r); check("R9 gie kept", r, 32'h8000_0000);
      check("R9 irq kept", {31'd0, irq}, 1);

      // R8 key write
      wr(A_RS, 32'h0000_000A);
      check("R8 pulse high", {31'd0, srst}, 1);
      @(negedge clk);
      check("R8 pulse one cycle", {31'd0, srst}, 0);
      rd(A_ST, r);  check("R8 stat wiped", r, 0);
      rd(A_EN, r);  check("R8 en wiped", r, 0);
      rd(A_GIE, r); check("R8 gie wiped", r, 0);
      check("R8 irq low", {31'd0, irq}, 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule